// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block holds a small bank of transmit mailboxes for a CAN controller and decides which one goes to the bit-level transmitter next. Software writes an identifier, a length code and eight data bytes into an empty mailbox and then raises a request. From then on the mailbox is locked. It competes with the other requested mailboxes until it wins, waits for the bus to go idle, and is then presented to the transmitter.

Two ranking modes are available. In identifier mode the lowest identifier wins, and on equal identifiers the lower mailbox index wins. In request-order mode each mailbox carries a rank that records the order of its request, and the oldest request wins whatever its identifier. The transmitter reports the outcome with a one-cycle done pulse and a result. A success frees the mailbox. A failure puts the mailbox back into the competition. Per-mailbox flags record completion, success, arbitration loss and transmit error, and software clears them by writing ones.

Each mailbox runs its own state machine:
- EMPTY goes to PENDING when a request arrives.
- PENDING goes to SCHED when the mailbox wins the ranking.
- SCHED goes back to PENDING when a better mailbox displaces it while the bus is busy.
- SCHED goes to XMIT when the bus is idle.
- XMIT goes to EMPTY on a successful done.
- XMIT goes to PENDING on a failed done.

Top module: `can_txmb_sched`

## Requirements
- R1: Each mailbox reports its state on two bits of `mb_state` (mailbox i at bits 2i+1:2i): 0 EMPTY, 1 PENDING, 2 SCHED, 3 XMIT. After reset every mailbox is EMPTY, every flag is 0 and `tx_valid` is 0.
- R2: A request to an EMPTY mailbox makes it PENDING at the next clock edge. A request to a mailbox that is not EMPTY is ignored, and its request order is unchanged.
- R3: A write to the identifier, length or data of a mailbox that is not EMPTY is ignored. The stored values are the ones later presented on `tx_id`, `tx_dlc` and `tx_data`.
- R4: At most one mailbox is in SCHED or XMIT. While no mailbox is in XMIT and no scheduled mailbox is starting, the best-ranked mailbox among PENDING and SCHED becomes SCHED at the next edge, and a SCHED mailbox that loses returns to PENDING.
- R5: A SCHED mailbox enters XMIT only at an edge where `bus_idle` is 1. While a mailbox is in XMIT, `tx_valid` is 1 and `tx_mb`, `tx_id`, `tx_dlc` and `tx_data` show that mailbox's index and stored contents.
- R6: With `fifo_mode` at 0, the lowest identifier has the highest rank.
- R7: With `fifo_mode` at 0 and equal identifiers, the lower mailbox index wins.
- R8: With `fifo_mode` at 1, mailboxes are ranked by the order of their accepted requests, oldest first, regardless of identifier.
- R9: A `tx_done` with `tx_ok` at 1 returns the XMIT mailbox to EMPTY at that edge and sets its `flag_rqcp` and `flag_txok`.
- R10: A `tx_done` with `tx_ok` at 0 returns the XMIT mailbox to PENDING and clears its `flag_txok`. `flag_alst` is set if `tx_alst` is 1, and `flag_terr` is set if `tx_terr` is 1; both may be set.
- R11: Flags are sticky. `clr_en` with `clr_sel` clears the flags of that mailbox named by `clr_mask`: bit 0 completion, bit 1 success, bit 2 arbitration loss, bit 3 error. The other flags are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | 1 selects request-order ranking, 0 selects identifier ranking |
| wr_en | input | 1 | Load mailbox contents |
| wr_sel | input | 2 | Mailbox written |
| wr_id | input | 11 | Identifier to store |
| wr_dlc | input | 4 | Length code to store |
| wr_data | input | 64 | Data bytes to store |
| req_en | input | 1 | Transmit request |
| req_sel | input | 2 | Mailbox requested |
| clr_en | input | 1 | Flag clear strobe |
| clr_sel | input | 2 | Mailbox whose flags are cleared |
| clr_mask | input | 4 | Write-one-to-clear mask |
| bus_idle | input | 1 | Bus is idle, so a transmission may start |
| tx_done | input | 1 | Transmitter finished the current frame |
| tx_ok | input | 1 | Frame sent successfully |
| tx_alst | input | 1 | Arbitration was lost |
| tx_terr | input | 1 | Transmit error detected |
| tx_valid | output | 1 | A mailbox is in XMIT |
| tx_mb | output | 2 | Index of the transmitting mailbox |
| tx_id | output | 11 | Identifier being sent |
| tx_dlc | output | 4 | Length code being sent |
| tx_data | output | 64 | Data being sent |
| mb_state | output | 6 | Per-mailbox state codes |
| flag_rqcp | output | 3 | Request-complete flags |
| flag_txok | output | 3 | Transmit-OK flags |
| flag_alst | output | 3 | Arbitration-lost flags |
| flag_terr | output | 3 | Transmit-error flags |

## Verification
Every result is due one clock edge after its cause:
- A request becomes PENDING one edge later.
- A PENDING mailbox becomes SCHED at the following edge when no transmission is under way.
- A SCHED mailbox becomes XMIT at the first edge with the bus idle.
- A done pulse updates the state and flags at its own edge.
- A clear takes effect at the next edge.

The bench drives inputs at the falling edge and samples at the next falling edge, so each check lands exactly one rising edge after its stimulus. The bench also holds the bus busy during ranking so that the chosen mailbox can be observed while it sits in SCHED.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    typedef enum logic [1:0] {
        MB_EMPTY   = 2'd0,
        MB_PENDING = 2'd1,
        MB_SCHED   = 2'd2,
        MB_XMIT    = 2'd3
    } mb_state_e;

    localparam int FLAG_RQCP = 0;
    localparam int FLAG_TXOK = 1;
    localparam int FLAG_ALST = 2;
    localparam int FLAG_TERR = 3;

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
    import can_txmb_pkg::*;
#(
    parameter int ID_W   = 11,
    parameter int DLC_W  = 4,
    parameter int DATA_W = 64,
    parameter int RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DLC_W-1:0]  wr_dlc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req,
    input  logic [RANK_W-1:0] new_rank,
    input  logic              leave_vld,
    input  logic [RANK_W-1:0] leave_rank,
    input  logic              arb_en,
    input  logic              win,
    input  logic              bus_idle,
    input  logic              done,
    input  logic              ok,
    input  logic              alst_in,
    input  logic              terr_in,
    input  logic [3:0]        clr,
    output mb_state_e         state,
    output logic [ID_W-1:0]   id_q,
    output logic [DLC_W-1:0]  dlc_q,
    output logic [DATA_W-1:0] data_q,
    output logic [RANK_W-1:0] rank_q,
    output logic [3:0]        flags
);

    mb_state_e state_nx;
    logic      succ;
    logic      fail;

    assign succ = (state == MB_XMIT) && done && ok;
    assign fail = (state == MB_XMIT) && done && !ok;

    always_comb begin
        state_nx = state;
        unique case (state)
            MB_EMPTY:   if (req) state_nx = MB_PENDING;
            MB_PENDING: if (arb_en && win) state_nx = MB_SCHED;
            MB_SCHED: begin
                if (bus_idle)             state_nx = MB_XMIT;
                else if (arb_en && !win)  state_nx = MB_PENDING;
            end
            MB_XMIT:    if (done) state_nx = ok ? MB_EMPTY : MB_PENDING;
            default:    state_nx = MB_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MB_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q   <= '0;
            dlc_q  <= '0;
            data_q <= '0;
            rank_q <= '0;
            flags  <= '0;
        end else begin
            if (wr && state == MB_EMPTY) begin
                id_q   <= wr_id;
                dlc_q  <= wr_dlc;
                data_q <= wr_data;
            end
            if (req && state == MB_EMPTY)
                rank_q <= new_rank;
            else if (leave_vld && rank_q > leave_rank)
                rank_q <= rank_q - 1'b1;
            flags[FLAG_RQCP] <= (flags[FLAG_RQCP] & ~clr[FLAG_RQCP]) | succ;
            flags[FLAG_TXOK] <= succ ? 1'b1 : (fail ? 1'b0 : flags[FLAG_TXOK] & ~clr[FLAG_TXOK]);
            flags[FLAG_ALST] <= (flags[FLAG_ALST] & ~clr[FLAG_ALST]) | (fail & alst_in);
            flags[FLAG_TERR] <= (flags[FLAG_TERR] & ~clr[FLAG_TERR]) | (fail & terr_in);
        end
    end

    AST_REQ_TO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (req && state == MB_EMPTY) |=> (state == MB_PENDING)); // R2
    AST_LOCKED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state != MB_EMPTY) |=> ($stable(id_q) && $stable(dlc_q) && $stable(data_q))); // R3
    AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_SCHED && !bus_idle) |=> (state != MB_XMIT)); // R5
    AST_SUCCESS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        succ |=> (state == MB_EMPTY && flags[FLAG_RQCP] && flags[FLAG_TXOK])); // R9
    AST_FAIL_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (state == MB_PENDING && !flags[FLAG_TXOK])); // R10

endmodule

// File: rtl/can_txmb_arbiter.sv
module can_txmb_arbiter #(
    parameter int NMB   = 3,
    parameter int KEY_W = 11,
    localparam int SEL_W = (NMB > 1) ? $clog2(NMB) : 1
) (
    input  logic [NMB-1:0]       cand,
    input  logic [NMB*KEY_W-1:0] keys,
    output logic [NMB-1:0]       win
);

    logic             found;
    logic [SEL_W-1:0] best_idx;
    logic [KEY_W-1:0] best_key;

    always_comb begin
        found    = 1'b0;
        best_idx = '0;
        best_key = '0;
        for (int i = 0; i < NMB; i++) begin
            if (cand[i] && (!found || keys[i*KEY_W +: KEY_W] < best_key)) begin
                found    = 1'b1;
                best_idx = SEL_W'(i);
                best_key = keys[i*KEY_W +: KEY_W];
            end
        end
        for (int i = 0; i < NMB; i++)
            win[i] = found && (best_idx == SEL_W'(i));
    end

endmodule

// File: rtl/can_txmb_sched.sv
module can_txmb_sched
    import can_txmb_pkg::*;
#(
    parameter int NMB    = 3,
    parameter int ID_W   = 11,
    parameter int DLC_W  = 4,
    parameter int DATA_W = 64,
    localparam int SEL_W  = (NMB > 1) ? $clog2(NMB) : 1,
    localparam int CNT_W  = $clog2(NMB + 1),
    localparam int KEY_W  = (ID_W > SEL_W) ? ID_W : SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [DLC_W-1:0]  wr_dlc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req_en,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic              clr_en,
    input  logic [SEL_W-1:0]  clr_sel,
    input  logic [3:0]        clr_mask,
    input  logic              bus_idle,
    input  logic              tx_done,
    input  logic              tx_ok,
    input  logic              tx_alst,
    input  logic              tx_terr,
    output logic              tx_valid,
    output logic [SEL_W-1:0]  tx_mb,
    output logic [ID_W-1:0]   tx_id,
    output logic [DLC_W-1:0]  tx_dlc,
    output logic [DATA_W-1:0] tx_data,
    output logic [2*NMB-1:0]  mb_state,
    output logic [NMB-1:0]    flag_rqcp,
    output logic [NMB-1:0]    flag_txok,
    output logic [NMB-1:0]    flag_alst,
    output logic [NMB-1:0]    flag_terr
);

    mb_state_e          st    [NMB];
    logic [ID_W-1:0]    ids   [NMB];
    logic [DLC_W-1:0]   dlcs  [NMB];
    logic [DATA_W-1:0]  datas [NMB];
    logic [SEL_W-1:0]   ranks [NMB];
    logic [3:0]         flg   [NMB];

    logic [NMB-1:0]       is_sched, is_xmit, is_active, cand, win;
    logic [NMB*KEY_W-1:0] keys;
    logic                 arb_en;
    logic [CNT_W-1:0]     active_cnt;
    logic                 leave_vld;
    logic [SEL_W-1:0]     leave_rank;
    logic [SEL_W-1:0]     new_rank;

    always_comb begin
        active_cnt = '0;
        leave_vld  = 1'b0;
        leave_rank = '0;
        tx_mb      = '0;
        tx_id      = '0;
        tx_dlc     = '0;
        tx_data    = '0;
        for (int i = 0; i < NMB; i++) begin
            is_sched[i]  = (st[i] == MB_SCHED);
            is_xmit[i]   = (st[i] == MB_XMIT);
            is_active[i] = (st[i] != MB_EMPTY);
            cand[i]      = (st[i] == MB_PENDING) || is_sched[i];
            keys[i*KEY_W +: KEY_W] = fifo_mode ? KEY_W'(ranks[i]) : KEY_W'(ids[i]);
            active_cnt   = active_cnt + CNT_W'(is_active[i]);
            if (is_xmit[i]) begin
                tx_mb   = SEL_W'(i);
                tx_id   = ids[i];
                tx_dlc  = dlcs[i];
                tx_data = datas[i];
                if (tx_done && tx_ok) begin
                    leave_vld  = 1'b1;
                    leave_rank = ranks[i];
                end
            end
        end
        tx_valid = |is_xmit;
        arb_en   = !tx_valid && !(|is_sched && bus_idle);
        new_rank = SEL_W'(active_cnt - CNT_W'(leave_vld));
    end

    can_txmb_arbiter #(.NMB(NMB), .KEY_W(KEY_W)) u_arb (
        .cand (cand),
        .keys (keys),
        .win  (win)
    );

    for (genvar g = 0; g < NMB; g++) begin : g_slot
        can_txmb_slot #(
            .ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W), .RANK_W(SEL_W)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (wr_en && wr_sel == SEL_W'(g)),
            .wr_id      (wr_id),
            .wr_dlc     (wr_dlc),
            .wr_data    (wr_data),
            .req        (req_en && req_sel == SEL_W'(g)),
            .new_rank   (new_rank),
            .leave_vld  (leave_vld),
            .leave_rank (leave_rank),
            .arb_en     (arb_en),
            .win        (win[g]),
            .bus_idle   (bus_idle),
            .done       (tx_done),
            .ok         (tx_ok),
            .alst_in    (tx_alst),
            .terr_in    (tx_terr),
            .clr        ((clr_en && clr_sel == SEL_W'(g)) ? clr_mask : 4'b0000),
            .state      (st[g]),
            .id_q       (ids[g]),
            .dlc_q      (dlcs[g]),
            .data_q     (datas[g]),
            .rank_q     (ranks[g]),
            .flags      (flg[g])
        );
        assign mb_state[2*g +: 2] = st[g];
        assign flag_rqcp[g] = flg[g][FLAG_RQCP];
        assign flag_txok[g] = flg[g][FLAG_TXOK];
        assign flag_alst[g] = flg[g][FLAG_ALST];
        assign flag_terr[g] = flg[g][FLAG_TERR];
    end

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(is_sched | is_xmit)); // R4
    AST_XMIT_FROM_SCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !(|is_sched)) |=> !tx_valid); // R5

endmodule

// File: tb/can_txmb_sched_test.sv
module can_txmb_sched_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [10:0] wr_id = '0;
    logic [3:0]  wr_dlc = '0;
    logic [63:0] wr_data = '0;
    logic        req_en = 1'b0;
    logic [1:0]  req_sel = '0;
    logic        clr_en = 1'b0;
    logic [1:0]  clr_sel = '0;
    logic [3:0]  clr_mask = '0;
    logic        bus_idle = 1'b0;
    logic        tx_done = 1'b0;
    logic        tx_ok = 1'b0;
    logic        tx_alst = 1'b0;
    logic        tx_terr = 1'b0;
    logic        tx_valid;
    logic [1:0]  tx_mb;
    logic [10:0] tx_id;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic [5:0]  mb_state;
    logic [2:0]  flag_rqcp, flag_txok, flag_alst, flag_terr;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_txmb_sched uut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_id(wr_id), .wr_dlc(wr_dlc), .wr_data(wr_data),
        .req_en(req_en), .req_sel(req_sel),
        .clr_en(clr_en), .clr_sel(clr_sel), .clr_mask(clr_mask),
        .bus_idle(bus_idle), .tx_done(tx_done), .tx_ok(tx_ok),
        .tx_alst(tx_alst), .tx_terr(tx_terr),
        .tx_valid(tx_valid), .tx_mb(tx_mb), .tx_id(tx_id), .tx_dlc(tx_dlc), .tx_data(tx_data),
        .mb_state(mb_state), .flag_rqcp(flag_rqcp), .flag_txok(flag_txok),
        .flag_alst(flag_alst), .flag_terr(flag_terr)
    );

    function automatic logic [1:0] st(input int i);
        return mb_state[2*i +: 2];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int mb, input logic [10:0] id, input logic [3:0] dlc, input logic [63:0] d);
        wr_en = 1'b1; wr_sel = 2'(mb); wr_id = id; wr_dlc = dlc; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic request(input int mb);
        req_en = 1'b1; req_sel = 2'(mb);
        @(negedge clk);
        req_en = 1'b0;
    endtask

    task automatic clear(input int mb, input logic [3:0] m);
        clr_en = 1'b1; clr_sel = 2'(mb); clr_mask = m;
        @(negedge clk);
        clr_en = 1'b0;
    endtask

    // Entry: mailbox mb is SCHED, bus busy. Exit: one arbitration edge after done.
    task automatic serve(input string tag, input int mb, input logic [10:0] id,
                         input logic ok, input logic al, input logic te);
        bus_idle = 1'b1;
        @(negedge clk);
        chk({tag, " R5 tx_valid"}, tx_valid, 1);
        chk({tag, " R5 tx_mb"}, tx_mb, mb);
        chk({tag, " R5 tx_id"}, tx_id, id);
        bus_idle = 1'b0;
        tx_done = 1'b1; tx_ok = ok; tx_alst = al; tx_terr = te;
        @(negedge clk);
        tx_done = 1'b0; tx_ok = 1'b0; tx_alst = 1'b0; tx_terr = 1'b0;
        chk({tag, " R9/R10 state after done"}, st(mb), ok ? 0 : 1);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 states empty", mb_state, 0);
        chk("R1 flags clear", {flag_rqcp, flag_txok, flag_alst, flag_terr}, 0);
        chk("R1 tx_valid low", tx_valid, 0);
    endtask

    task automatic t_basic;
        bus_idle = 1'b1;
        load(0, 11'h123, 4'd8, 64'h0123_4567_89AB_CDEF);
        request(0);
        chk("R2 request to pending", st(0), 1);
        load(0, 11'h7FF, 4'd1, 64'h0);
        chk("R4 pending to sched", st(0), 2);
        @(negedge clk);
        chk("R5 started on idle bus", st(0), 3);
        chk("R3 id locked", tx_id, 11'h123);
        chk("R3 dlc locked", tx_dlc, 4'd8);
        chk("R5 data shown", tx_data, 64'h0123_4567_89AB_CDEF);
        bus_idle = 1'b0;
        tx_done = 1'b1; tx_ok = 1'b1;
        @(negedge clk);
        tx_done = 1'b0; tx_ok = 1'b0;
        chk("R9 back to empty", st(0), 0);
        chk("R9 rqcp and txok", {flag_rqcp[0], flag_txok[0]}, 2'b11);
        clear(0, 4'hF);
        chk("R11 full clear", {flag_rqcp[0], flag_txok[0]}, 0);
    endtask

    task automatic t_idprio;
        fifo_mode = 1'b0;
        load(0, 11'h200, 4'd2, 64'hA0);
        load(1, 11'h100, 4'd2, 64'hA1);
        load(2, 11'h100, 4'd2, 64'hA2);
        request(0);
        request(1);
        request(2);
        @(negedge clk);
        chk("R7 tie to lower index", st(1), 2);
        chk("R4 displaced back to pending", st(0), 1);
        chk("R5 no start while busy", tx_valid, 0);
        serve("id mb1", 1, 11'h100, 1, 0, 0);
        chk("R6 lower id next", st(2), 2);
        serve("id mb2 fail", 2, 11'h100, 0, 1, 0);
        chk("R10 alst set", flag_alst[2], 1);
        chk("R10 txok clear", flag_txok[2], 0);
        chk("R10 retry scheduled", st(2), 2);
        serve("id mb2 retry", 2, 11'h100, 1, 0, 0);
        chk("R11 alst sticky", flag_alst[2], 1);
        serve("id mb0", 0, 11'h200, 1, 0, 0);
        clear(2, 4'b0100);
        chk("R11 partial clear", {flag_alst[2], flag_txok[2], flag_rqcp[2]}, 3'b011);
    endtask

    task automatic t_fifo;
        fifo_mode = 1'b1;
        load(0, 11'h100, 4'd3, 64'hB0);
        load(1, 11'h050, 4'd3, 64'hB1);
        load(2, 11'h300, 4'd3, 64'hB2);
        request(2);
        request(0);
        request(1);
        request(2);
        chk("R8 oldest scheduled", st(2), 2);
        chk("R2 re-request ignored", st(0), 1);
        serve("fifo mb2", 2, 11'h300, 1, 0, 0);
        chk("R8 second oldest despite id", st(0), 2);
        serve("fifo mb0 fail", 0, 11'h100, 0, 1, 1);
        chk("R10 terr set", flag_terr[0], 1);
        chk("R10 both causes", flag_alst[0], 1);
        chk("R10 txok cleared from 1", flag_txok[0], 0);
        chk("R8 retry keeps age", st(0), 2);
        serve("fifo mb0 retry", 0, 11'h100, 1, 0, 0);
        serve("fifo mb1", 1, 11'h050, 1, 0, 0);
        chk("R1 all empty at end", mb_state, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_idprio();
        t_fifo();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule